// File: doc/BRIEF.md
# Host Register Port for a Dual-Direction Queue

This block is the host-facing front end of a device that holds two opposing data queues. A host processor reaches it over an asynchronous strobe bus made of an active-low select, an active-low data strobe, a read/write line and two address bits, plus an 18-bit data bus. The select, strobe and read/write lines are brought into the system clock domain through two-flop synchronizers. Edge detection then turns every bus access into exactly one single-cycle action.

Each access goes to one of six resources, chosen by the address bits together with the read/write line:

- the host-to-far queue write port;
- the far-to-host queue read port;
- a command register;
- a status register;
- a window onto eight configuration registers, where the entry is chosen by an index held in the command register;
- a 9-bit message latch that carries a short message straight to the far-side device without passing through either queue.

The far side empties the message latch with a one-cycle take pulse.

Top module: `hostRegPort`

## Requirements
- R1: A strobe cycle made while select (`csN`) is high has no effect: no register changes, no push and no pop.
- R2: With `rwN` high, read data is loaded into `dOut` on the falling edge of `dsN`, within 4 clock cycles. The rising edge that ends the read causes no second action, so exactly one pop occurs per queue read.
- R3: With `rwN` low, write data is committed on the rising edge of `dsN`. While the strobe is still low, the target register keeps its old value.
- R4: The resources are decoded from (`rwN`, `addr`) as follows:
  - (0,0): push into the host-to-far queue.
  - (1,0): pop from the far-to-host queue.
  - (0,1): write the command register.
  - (1,1): read the status register.
  - (x,2): access the configuration entry selected by command bits [2:0].
  - (x,3): access the message latch.
- R5: The status word has the message-valid flag in bit 0, `abFull` in bit 1, `baEmpty` in bit 2 and the configuration index in bits [5:3]. Bits [17:6] read as zero.
- R6: A queue write pulses `abPush` for one cycle and carries the written word on `abPushData`. No pulse is produced while `abFull` is high.
- R7: A queue read pulses `baPop` for one cycle and returns `baPopData`. While `baEmpty` is high there is no pulse and the read returns zero.
- R8: A write to the message latch stores `dIn[8:0]` on `byMsg` and sets `byValid`. A read of the latch returns the message zero-extended to 18 bits.
- R9: A `byTake` pulse clears `byValid`. If a host write to the latch lands in the same cycle, the write wins and `byValid` stays set.
- R10: After reset, `dOut`, the command word, all configuration entries and `byValid` are zero.
- R11: The eight configuration entries are stored independently. Each one reads back what was last written to it.
- R12: `dOutEn` is high only while a selected read has its strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset of all state |
| csN | input | 1 | Host select, active low |
| dsN | input | 1 | Host data strobe, active low |
| rwN | input | 1 | High = read, low = write |
| addr | input | 2 | Host address bits |
| dIn | input | 18 | Host write data |
| dOut | output | 18 | Host read data |
| dOutEn | output | 1 | Host data bus drive enable |
| abFull | input | 1 | Host-to-far queue full |
| abPush | output | 1 | Push pulse into the host-to-far queue |
| abPushData | output | 18 | Word pushed into the host-to-far queue |
| baEmpty | input | 1 | Far-to-host queue empty |
| baPopData | input | 18 | Head word of the far-to-host queue |
| baPop | output | 1 | Pop pulse from the far-to-host queue |
| byTake | input | 1 | Far side has consumed the message |
| byMsg | output | 9 | Message latch contents |
| byValid | output | 1 | Message latch holds an unread message |
| cmdWord | output | 18 | Command register contents |
| cfgFlat | output | 144 | All eight configuration entries, entry 0 in the low bits |

## Verification
The bench watches for edge confusion in three places.
- A read must be answered before the strobe rises, and it must pop only once. A design that acted on the rising edge would return stale data, and one that acted on both edges would pop twice.
- A write is observed while the strobe is still low. A design that committed on the falling edge would already show the new value there.
- Accesses with select high must leave everything untouched.

Some cases are aimed at the boundaries.
- Pushes against a full queue and pops from an empty queue must produce no pulse.
- Each of the eight configuration indices is written with a distinct value and then read back, so a design that aliases or mis-indexes entries is caught.
- A far-side take is made to collide with a host write to the latch. A design that lets the take win would report the new message as not valid.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  // One single-cycle action per decoded host access.
  typedef struct packed {
    logic wrAb;   // push into host-to-far queue
    logic rdBa;   // pop from far-to-host queue
    logic wrCmd;  // command register write
    logic rdStat; // status read
    logic wrCfg;  // indexed configuration write
    logic rdCfg;  // indexed configuration read
    logic wrByp;  // message latch write
    logic rdByp;  // message latch read
  } hostStb_t;
endpackage

// File: rtl/hrpCtrl.sv
module hrpCtrl
  import hrp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          dsN,
  input  logic          rwN,
  input  logic [AW-1:0] addr,
  output hostStb_t      stb,
  output logic          dOutEn
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] csSy, dsSy, rwSy;
  logic dsPrev;
  logic csS, dsS, rwS;
  logic rdEv, wrEv;

  // Metastability chains; the idle level of every line is high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSy   <= '1;
      dsSy   <= '1;
      rwSy   <= '1;
      dsPrev <= 1'b1;
    end else begin
      csSy   <= {csSy[LAST-1:0], csN};
      dsSy   <= {dsSy[LAST-1:0], dsN};
      rwSy   <= {rwSy[LAST-1:0], rwN};
      dsPrev <= dsSy[LAST];
    end
  end

  assign csS = csSy[LAST];
  assign dsS = dsSy[LAST];
  assign rwS = rwSy[LAST];

  // Reads launch on the falling strobe, writes commit on the rising strobe.
  assign rdEv = dsPrev & ~dsS & ~csS & rwS;
  assign wrEv = ~dsPrev & dsS & ~csS & ~rwS;

  always_comb begin
    stb = '0;
    unique case (addr)
      2'd0: begin stb.wrAb  = wrEv; stb.rdBa   = rdEv; end
      2'd1: begin stb.wrCmd = wrEv; stb.rdStat = rdEv; end
      2'd2: begin stb.wrCfg = wrEv; stb.rdCfg  = rdEv; end
      default: begin stb.wrByp = wrEv; stb.rdByp = rdEv; end
    endcase
  end

  assign dOutEn = ~csS & rwS & ~dsS;

  // R4: at most one resource acts per cycle
  a_r4_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R1: any action traces back to select being low at the pin
  a_r1_select_gates: assert property (@(posedge clk) disable iff (!rstN)
    (stb != '0) |-> !$past(csN, SYNC_STAGES));
endmodule

// File: rtl/hrpDatapath.sv
module hrpDatapath
  import hrp_pkg::*;
#(
  parameter int DW   = 18,
  parameter int NCFG = 8,
  parameter int BYW  = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  hostStb_t         stb,
  input  logic [DW-1:0]    dIn,
  input  logic             abFull,
  input  logic             baEmpty,
  input  logic [DW-1:0]    baPopData,
  input  logic             byTake,
  output logic [DW-1:0]    dOut,
  output logic             abPush,
  output logic [DW-1:0]    abPushData,
  output logic             baPop,
  output logic [DW-1:0]    cmdWord,
  output logic [NCFG*DW-1:0] cfgFlat,
  output logic [BYW-1:0]   byMsg,
  output logic             byValid
);
  localparam int IW = $clog2(NCFG);
  localparam int ST_IDX = 3;

  logic [DW-1:0] cfgMem [NCFG];
  logic [IW-1:0] cfgIdx;
  logic [DW-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cmdWord <= '0;
    else if (stb.wrCmd) cmdWord <= dIn;
  end

  assign cfgIdx = cmdWord[IW-1:0];

  for (genvar g = 0; g < NCFG; g++) begin : gCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 cfgMem[g] <= '0;
      else if (stb.wrCfg && cfgIdx == IW'(g))    cfgMem[g] <= dIn;
    end
    assign cfgFlat[g*DW +: DW] = cfgMem[g];
  end

  // Message latch: host write wins over a same-cycle far-side take.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byMsg   <= '0;
      byValid <= 1'b0;
    end else if (stb.wrByp) begin
      byMsg   <= dIn[BYW-1:0];
      byValid <= 1'b1;
    end else if (byTake) begin
      byValid <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[0] = byValid;
    statusWord[1] = abFull;
    statusWord[2] = baEmpty;
    statusWord[ST_IDX +: IW] = cfgIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abPush     <= 1'b0;
      abPushData <= '0;
      baPop      <= 1'b0;
    end else begin
      abPush <= stb.wrAb & ~abFull;
      baPop  <= stb.rdBa & ~baEmpty;
      if (stb.wrAb) abPushData <= dIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dOut <= '0;
    else if (stb.rdBa)   dOut <= baEmpty ? '0 : baPopData;
    else if (stb.rdStat) dOut <= statusWord;
    else if (stb.rdCfg)  dOut <= cfgMem[cfgIdx];
    else if (stb.rdByp)  dOut <= {{(DW-BYW){1'b0}}, byMsg};
  end

  // R8: a latch write leaves the written message valid
  a_r8_latch_set: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByp |=> (byValid && byMsg == $past(dIn[BYW-1:0])));

  // R9: a take with no competing write empties the latch
  a_r9_take_clears: assert property (@(posedge clk) disable iff (!rstN)
    (byTake && !stb.wrByp) |=> !byValid);

  // R6: a full queue never sees a push
  a_r6_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    abFull |=> !abPush);

  // R7: an empty queue never sees a pop
  a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    baEmpty |=> !baPop);
endmodule

// File: rtl/hostRegPort.sv
module hostRegPort
  import hrp_pkg::*;
#(
  parameter int DW   = 18,
  parameter int NCFG = 8,
  parameter int BYW  = 9,
  parameter int AW   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               dsN,
  input  logic               rwN,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      dIn,
  output logic [DW-1:0]      dOut,
  output logic               dOutEn,
  input  logic               abFull,
  output logic               abPush,
  output logic [DW-1:0]      abPushData,
  input  logic               baEmpty,
  input  logic [DW-1:0]      baPopData,
  output logic               baPop,
  input  logic               byTake,
  output logic [BYW-1:0]     byMsg,
  output logic               byValid,
  output logic [DW-1:0]      cmdWord,
  output logic [NCFG*DW-1:0] cfgFlat
);
  hostStb_t stb;

  hrpCtrl #(.SYNC_STAGES(2), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .dsN(dsN), .rwN(rwN),
    .addr(addr), .stb(stb), .dOutEn(dOutEn)
  );

  hrpDatapath #(.DW(DW), .NCFG(NCFG), .BYW(BYW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dIn(dIn),
    .abFull(abFull), .baEmpty(baEmpty), .baPopData(baPopData),
    .byTake(byTake), .dOut(dOut), .abPush(abPush),
    .abPushData(abPushData), .baPop(baPop), .cmdWord(cmdWord),
    .cfgFlat(cfgFlat), .byMsg(byMsg), .byValid(byValid)
  );
endmodule

// File: tb/hostRegPort_tb.sv
module hostRegPort_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, dsN = 1'b1, rwN = 1'b1;
  logic [1:0] addr = '0;
  logic [17:0] dIn = '0;
  logic [17:0] dOut;
  logic dOutEn;
  logic abFull = 1'b0, baEmpty = 1'b0, byTake = 1'b0;
  logic abPush, baPop, byValid;
  logic [17:0] abPushData, baPopData = '0, cmdWord;
  logic [8:0] byMsg;
  logic [143:0] cfgFlat;

  int checks = 0, fails = 0;
  int pushCnt = 0, popCnt = 0;
  logic [17:0] lastPush = '0;
  bit done = 0;

  logic [17:0] expQ[$];
  string tagQ[$];
  event sampleEv;

  always #4 clk = ~clk;

  hostRegPort u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .dsN(dsN), .rwN(rwN), .addr(addr),
    .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn), .abFull(abFull),
    .abPush(abPush), .abPushData(abPushData), .baEmpty(baEmpty),
    .baPopData(baPopData), .baPop(baPop), .byTake(byTake), .byMsg(byMsg),
    .byValid(byValid), .cmdWord(cmdWord), .cfgFlat(cfgFlat)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pulse monitors sample between edges.
  always @(negedge clk) begin
    if (abPush) begin pushCnt++; lastPush = abPushData; end
    if (baPop) popCnt++;
  end

  // Scoreboard monitor: compares dOut each time a read reaches its sample point.
  initial forever begin
    @(sampleEv);
    if (expQ.size() == 0) begin
      check("scoreboard empty", 0, 1);
    end else begin
      logic [17:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, dOut, e);
    end
  end

  task automatic hostRead(logic [1:0] a, logic [17:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk); csN = 1'b0; rwN = 1'b1; addr = a;
    @(negedge clk); dsN = 1'b0;
    repeat (5) @(negedge clk);
    check("R12 dOutEn during read", dOutEn, 1);
    ->sampleEv;   // sampled before the strobe rises (R2)
    dsN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 dOutEn after read", dOutEn, 0);
  endtask

  task automatic hostWrite(logic [1:0] a, logic [17:0] d, logic sel);
    @(negedge clk); csN = ~sel; rwN = 1'b0; addr = a; dIn = d;
    @(negedge clk); dsN = 1'b0;
    repeat (5) @(negedge clk);
    dsN = 1'b1;
    repeat (5) @(negedge clk);
    csN = 1'b1; rwN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    check("R10 dOut reset", dOut, 0);
    check("R10 cmd reset", cmdWord, 0);
    check("R10 cfg reset", cfgFlat != '0, 0);
    check("R10 byValid reset", byValid, 0);
    check("R12 dOutEn idle", dOutEn, 0);

    // R1 deselected write ignored
    hostWrite(2'd1, 18'h3ABCD, 1'b0);
    check("R1 cmd untouched", cmdWord, 0);
    hostWrite(2'd0, 18'h00111, 1'b0);
    check("R1 no push", pushCnt, 0);

    // R3 commit on rising strobe
    @(negedge clk); csN = 1'b0; rwN = 1'b0; addr = 2'd1; dIn = 18'h12345;
    @(negedge clk); dsN = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 old value while strobe low", cmdWord, 0);
    dsN = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 committed after rise", cmdWord, 18'h12345);
    csN = 1'b1; rwN = 1'b1;
    repeat (3) @(negedge clk);

    // R11 / R4 config window, all indices
    for (int i = 0; i < 8; i++) begin
      hostWrite(2'd1, 18'(i), 1'b1);
      hostWrite(2'd2, 18'h20000 | 18'(i * 18'h111), 1'b1);
    end
    for (int i = 7; i >= 0; i--) begin
      hostWrite(2'd1, 18'(i), 1'b1);
      hostRead(2'd2, 18'h20000 | 18'(i * 18'h111), "R11 config readback");
    end

    // R5 status layout (index 5, flags set)
    hostWrite(2'd1, 18'd5, 1'b1);
    abFull = 1'b1; baEmpty = 1'b1;
    hostRead(2'd1, 18'((5 << 3) | 6), "R5 status flags");
    abFull = 1'b0; baEmpty = 1'b0;
    hostRead(2'd1, 18'(5 << 3), "R5 status clear");

    // R6 push path
    hostWrite(2'd0, 18'h2BEEF, 1'b1);
    check("R6 push count", pushCnt, 1);
    check("R6 push data", lastPush, 18'h2BEEF);
    abFull = 1'b1;
    hostWrite(2'd0, 18'h01234, 1'b1);
    check("R6 no push when full", pushCnt, 1);
    abFull = 1'b0;

    // R2 / R7 pop path
    baPopData = 18'h15A5A;
    hostRead(2'd0, 18'h15A5A, "R2 R7 queue read data");
    check("R2 single pop per read", popCnt, 1);
    baEmpty = 1'b1;
    hostRead(2'd0, 18'h0, "R7 empty read zero");
    check("R7 no pop when empty", popCnt, 1);
    baEmpty = 1'b0;

    // R8 message latch
    hostWrite(2'd3, 18'h3F1A5, 1'b1);
    check("R8 msg", byMsg, 9'h1A5);
    check("R8 valid", byValid, 1);
    hostRead(2'd3, 18'h001A5, "R8 latch readback");
    hostRead(2'd1, 18'((5 << 3) | 1), "R5 status mirrors valid");

    // R9 take clears
    @(negedge clk); byTake = 1'b1;
    @(negedge clk); byTake = 1'b0;
    check("R9 take clears", byValid, 0);

    // R9 collision: take lands in the commit cycle
    @(negedge clk); csN = 1'b0; rwN = 1'b0; addr = 2'd3; dIn = 18'h00077;
    @(negedge clk); dsN = 1'b0;
    repeat (5) @(negedge clk);
    dsN = 1'b1;
    @(negedge clk);
    @(negedge clk); byTake = 1'b1;
    @(negedge clk); byTake = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 write wins collision", byValid, 1);
    check("R9 collision msg", byMsg, 9'h077);
    csN = 1'b1; rwN = 1'b1;
    repeat (3) @(negedge clk);

    check("scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule